// File: doc/BRIEF.md
# Ternary 1-to-9 Demultiplexer

This block steers one ternary data digit onto one of nine ternary output lanes. The choice of lane comes from two ternary select digits. Each digit (trit) travels on two wires with a fixed code: `00` means 0, `01` means 1, `10` means 2, and `11` is not a legal value. The structure follows a reversible construction. A select decoder raises exactly one of its nine lines to the value 2 and holds every other line at 0. Each decoder line gates one conditional GF(3) adder stage. That stage adds the data trit into a lane whose starting value is the constant 0. Only the stage whose gate line is 2 performs its addition, so only that lane ends up holding the data trit. Every other lane stays at 0.

The data trit and the nine decoder lines are also brought out as by-product outputs, as the reversible form requires. An error flag reports any illegal input code. All outputs are registered once and share one synchronous, active-high reset. A result appears on the outputs one clock after its inputs.

Top module: `tdmx_top`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, the outputs `dmx_out`, `dec_lines`, `data_pass` and `code_err` are all zero.
- R2: For legal inputs, one cycle later lane number k = 3·(upper select trit) + (lower select trit) carries the data trit. Lane k sits at `dmx_out[2k+1:2k]`. The lower select trit is `sel[1:0]` and the upper select trit is `sel[3:2]`. The trit code is 00=0, 01=1, 10=2.
- R3: For legal inputs, every lane other than k reads 00 one cycle later. This also holds when the data trit is 0, in which case all nine lanes read 00.
- R4: For legal inputs, one cycle later decoder line k reads 10 (value 2) and the other eight lines read 00. Line j sits at `dec_lines[2j+1:2j]`.
- R5: For legal inputs, `data_pass` equals the data trit one cycle later.
- R6: If the code 11 appears on `data_in` or on either select trit, then one cycle later `code_err` is 1 and `dmx_out`, `dec_lines` and `data_pass` are all zero.
- R7: For legal inputs, `code_err` is 0 one cycle later, including the first legal cycle after an illegal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 2 | Data trit to be routed |
| sel | input | 4 | Two select trits; the lower trit is in bits [1:0] |
| dmx_out | output | 18 | Nine output lanes, two bits each |
| dec_lines | output | 18 | Decoder lines passed out as by-product outputs |
| data_pass | output | 2 | Data trit passed through as a by-product output |
| code_err | output | 1 | Set when any input carries the illegal code 11 |

## Verification
The properties that check routing, lane clearing and pass-through assume the inputs held a legal code in the previous cycle. They compute the expected lane from their own registered copy of the select trits. They guard on a flag showing that the previous cycle was outside reset. The error property covers the illegal case separately. The stimulus drives legal codes in every table walk. It brings in 11 only through directed cases, on each trit position in turn, and the expected error flag is predicted for those cases.

// File: rtl/tdmx_pkg.sv
package tdmx_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_0   = 2'b00;
  localparam trit_t TRIT_1   = 2'b01;
  localparam trit_t TRIT_2   = 2'b10;
  localparam trit_t TRIT_BAD = 2'b11;

  // GF(3) sum of two legal trits
  function automatic trit_t gf3_add(input trit_t a, input trit_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  function automatic logic trit_illegal(input trit_t t);
    return t == TRIT_BAD;
  endfunction
endpackage

// File: rtl/tdmx_decoder.sv
module tdmx_decoder
  import tdmx_pkg::*;
#(
  parameter int NSEL = 2,
  localparam int NOUT = 3 ** NSEL
) (
  input  logic [2*NSEL-1:0] sel,
  output logic [2*NOUT-1:0] lines
);
  for (genvar j = 0; j < NOUT; j++) begin : g_line
    logic hit;
    always_comb begin
      hit = 1'b1;
      for (int k = 0; k < NSEL; k++) begin
        if (sel[2*k +: 2] != 2'((j / (3 ** k)) % 3)) hit = 1'b0;
      end
    end
    // active line is 2, idle lines are 0
    assign lines[2*j +: 2] = hit ? TRIT_2 : TRIT_0;
  end
endmodule

// File: rtl/tdmx_cfstage.sv
module tdmx_cfstage
  import tdmx_pkg::*;
(
  input  trit_t ctrl,
  input  trit_t addend,
  input  trit_t target_in,
  output trit_t target_out
);
  // conditional GF(3) adder: acts only while the control trit is 2
  assign target_out = (ctrl == TRIT_2) ? gf3_add(addend, target_in) : target_in;
endmodule

// File: rtl/tdmx_top.sv
module tdmx_top
  import tdmx_pkg::*;
#(
  parameter int NSEL = 2,
  localparam int NOUT = 3 ** NSEL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        data_in,
  input  logic [2*NSEL-1:0] sel,
  output logic [2*NOUT-1:0] dmx_out,
  output logic [2*NOUT-1:0] dec_lines,
  output logic [1:0]        data_pass,
  output logic              code_err
);
  logic [2*NOUT-1:0] lines_c;
  logic [2*NOUT-1:0] lanes_c;
  logic [NSEL-1:0]   sel_bad;
  logic              err_c;

  tdmx_decoder #(.NSEL(NSEL)) u_dec (
    .sel   (sel),
    .lines (lines_c)
  );

  for (genvar k = 0; k < NSEL; k++) begin : g_selchk
    assign sel_bad[k] = trit_illegal(sel[2*k +: 2]);
  end

  assign err_c = trit_illegal(data_in) | (|sel_bad);

  for (genvar j = 0; j < NOUT; j++) begin : g_stage
    tdmx_cfstage u_stage (
      .ctrl       (lines_c[2*j +: 2]),
      .addend     (data_in),
      .target_in  (TRIT_0),
      .target_out (lanes_c[2*j +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || err_c) begin
      dmx_out   <= '0;
      dec_lines <= '0;
      data_pass <= '0;
    end else begin
      dmx_out   <= lanes_c;
      dec_lines <= lines_c;
      data_pass <= data_in;
    end
    code_err <= rst ? 1'b0 : err_c;
  end
endmodule

// File: rtl/tdmx_checker.sv
module tdmx_checker #(
  parameter int NSEL = 2,
  localparam int NOUT = 3 ** NSEL
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        data_in,
  input logic [2*NSEL-1:0] sel,
  input logic [2*NOUT-1:0] dmx_out,
  input logic [2*NOUT-1:0] dec_lines,
  input logic [1:0]        data_pass,
  input logic              code_err
);
  logic       armed = 1'b0;
  logic       rst_q = 1'b0;
  logic       bad_q = 1'b0;
  logic [1:0] din_q = 2'b00;
  int         idx_q = 0;

  always_ff @(posedge clk) begin
    int  acc;
    logic bad;
    acc = 0;
    bad = (data_in == 2'b11);
    for (int k = 0; k < NSEL; k++) begin
      acc = acc + int'(sel[2*k +: 2]) * (3 ** k);
      if (sel[2*k +: 2] == 2'b11) bad = 1'b1;
    end
    armed <= !rst;
    rst_q <= rst;
    bad_q <= bad;
    din_q <= data_in;
    idx_q <= acc;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst_q |-> (dmx_out == '0 && dec_lines == '0 && data_pass == '0 && !code_err));

  assert_route_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !bad_q) |-> dmx_out[2*idx_q +: 2] == din_q);

  assert_single_lane_R3: assert property (@(posedge clk) disable iff (rst)
    armed |-> $countones(dmx_out) <= 1);

  assert_dec_line_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && !bad_q) |-> (dec_lines[2*idx_q +: 2] == 2'b10 && $countones(dec_lines) == 1));

  assert_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !bad_q) |-> data_pass == din_q);

  assert_err_flag_R6: assert property (@(posedge clk) disable iff (rst)
    armed |-> code_err == bad_q);

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    code_err |-> (dmx_out == '0 && dec_lines == '0 && data_pass == '0));
endmodule

bind tdmx_top tdmx_checker #(.NSEL(NSEL)) u_chk (.*);

// File: tb/tb_tdmx_top.sv
module tb_tdmx_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSEL = 2;
  localparam int NOUT = 9;
  localparam int WATCHDOG = 200000;

  // {upper select trit, lower select trit}, walked in a scrambled order
  localparam logic [3:0] SEL_TAB [9] = '{
    4'b1010, 4'b0000, 4'b0110, 4'b1000, 4'b0001,
    4'b0101, 4'b0010, 4'b1001, 4'b0100 };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        data_in = 2'b00;
  logic [2*NSEL-1:0] sel = '0;
  logic [2*NOUT-1:0] dmx_out;
  logic [2*NOUT-1:0] dec_lines;
  logic [1:0]        data_pass;
  logic              code_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdmx_top #(.NSEL(NSEL)) dut (
    .clk(clk), .rst(rst), .data_in(data_in), .sel(sel),
    .dmx_out(dmx_out), .dec_lines(dec_lines),
    .data_pass(data_pass), .code_err(code_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample one full cycle later (one register stage)
  task automatic apply(input logic [1:0] d, input logic [3:0] s);
    @(negedge clk);
    data_in = d;
    sel = s;
    @(negedge clk);
  endtask

  task automatic check_legal(input logic [1:0] d, input logic [3:0] s);
    int idx;
    logic [2*NOUT-1:0] exp_lane;
    logic [2*NOUT-1:0] exp_line;
    logic [2*NOUT-1:0] mask;
    idx = 3 * int'(s[3:2]) + int'(s[1:0]);
    exp_lane = '0; exp_lane[2*idx +: 2] = d;
    exp_line = '0; exp_line[2*idx +: 2] = 2'b10;
    mask = '1;     mask[2*idx +: 2] = 2'b00;
    check("R2 selected lane", 32'(dmx_out[2*idx +: 2]), 32'(d));
    check("R3 other lanes zero", 32'(dmx_out & mask), 32'(exp_lane & mask));
    check("R4 decoder lines", 32'(dec_lines), 32'(exp_line));
    check("R5 data pass", 32'(data_pass), 32'(d));
    check("R7 no error", 32'(code_err), 32'd0);
  endtask

  task automatic check_illegal(input string tag);
    check({tag, " R6 flag"}, 32'(code_err), 32'd1);
    check({tag, " R6 lanes zero"}, 32'(dmx_out), 32'd0);
    check({tag, " R6 lines zero"}, 32'(dec_lines), 32'd0);
    check({tag, " R6 pass zero"}, 32'(data_pass), 32'd0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 lanes", 32'(dmx_out), 32'd0);
    check("R1 lines", 32'(dec_lines), 32'd0);
    check("R1 pass", 32'(data_pass), 32'd0);
    check("R1 flag", 32'(code_err), 32'd0);
    rst = 1'b0;

    // table walk: every select pair with every legal data trit
    for (int v = 0; v < 9; v++) begin
      for (int d = 0; d < 3; d++) begin
        apply(2'(d), SEL_TAB[v]);
        check_legal(2'(d), SEL_TAB[v]);
      end
    end

    // R6: illegal data, then each illegal select trit
    apply(2'b11, 4'b0101);
    check_illegal("bad data");
    apply(2'b01, 4'b0011);
    check_illegal("bad low sel");
    apply(2'b10, 4'b1100);
    check_illegal("bad high sel");
    // R7: recovery on the next legal cycle
    apply(2'b10, 4'b1001);
    check_legal(2'b10, 4'b1001);

    // R1: reset while routing a nonzero value
    apply(2'b01, 4'b1010);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run lanes", 32'(dmx_out), 32'd0);
    check("R1 mid-run lines", 32'(dec_lines), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_legal(2'b01, 4'b1010);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule